// File: doc/BRIEF.md
# HDLC Interrupt Status and Mask Unit

This unit gathers eight event sources from an HDLC controller and its transmit and receive FIFOs. Each event is latched into a sticky 8-bit status register. A write-only mask register selects which latched bits may assert the single interrupt request line. One CPU register location serves both registers. A write loads the mask. A read returns the status and clears all of it at once.

Besides the interrupts, the unit produces three control effects that follow from the events:
- A receive overflow switches the receiver off until the next flag arrives.
- A transmit underrun commands an abort sequence.
- The transmit priority indication goes high when the transmitter starts draining data and drops when the closing flag of the last packet has gone out.

The HDLC bit engines and the FIFO storage are outside the unit. It sees only their levels, their strobes and their indications.

Top module: `hdlc_irq_unit`

## Requirements
- R1: After reset the mask is 0x00, the status reads 0x00, `irq` is low, `rx_enable` is high, and both `tx_abort` and `tx_prio_hi` are low. A write (`cpu_cs`=1, `cpu_we`=1) loads `cpu_wdata` into the mask on that clock edge.
- R2: A read (`cpu_cs`=1, `cpu_we`=0) shows the status on `cpu_rdata` in the same cycle and clears every status bit at the edge that ends the read. An event arriving in that same cycle is still latched afterwards. Status bits never clear without a read.
- R3: `irq` is high exactly when some visible status bit and its mask bit are both 1. The bit positions are: 7 collision, 6 receive end of packet, 5 transmit end of packet, 4 frame abort, 3 transmit low, 2 transmit underrun, 1 receive full, 0 receive overflow.
- R4: Bit 7 sets when `dbit_strobe` is high, `te_mode` and `tx_en` are both 1, and `echo_bit` differs from `tx_dbit`. While `te_mode` is 0, bit 7 reads 0 and does not drive `irq`.
- R5: Bit 6 sets on `rx_eop` and also on `rx_abort`.
- R6: Bit 4 sets on `rx_abort`.
- R7: Bit 5 sets on `tx_close_done`, and `tx_prio_hi` is low from the next cycle on. `tx_prio_hi` goes high in the cycle after a pop made while it was low.
- R8: Bit 3 sets when a pop without a push takes `tx_level` from 5 down to 4. Filling to 4, or a pop combined with a push, does not set it.
- R9: Bit 2 sets when a pop without a push empties the transmit FIFO (`tx_level` is 1) and `tx_pop_eop` is 0. `tx_abort` is then high for exactly the next cycle. Emptying with `tx_pop_eop` at 1 sets nothing.
- R10: Bit 1 sets when a push without a pop takes `rx_level` from 14 to 15. Lower crossings do not set it.
- R11: Bit 0 sets when a push without a pop arrives while `rx_level` is 16 (full). `rx_enable` is low from the next cycle and stays low until a cycle with `rx_flag`, after which it is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_cs | input | 1 | Register access select |
| cpu_we | input | 1 | 1 = write mask, 0 = read status |
| cpu_wdata | input | 8 | Mask write data |
| cpu_rdata | output | 8 | Status read data |
| irq | output | 1 | Interrupt request |
| te_mode | input | 1 | 1 = terminal side, 0 = network side |
| tx_en | input | 1 | Transmitter enabled |
| dbit_strobe | input | 1 | D-bit / echo-bit compare instant |
| tx_dbit | input | 1 | Transmitted D bit |
| echo_bit | input | 1 | Received echo bit |
| tx_level | input | 5 | Transmit FIFO fill level |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| tx_pop_eop | input | 1 | Byte being popped carries end-of-packet mark |
| tx_close_done | input | 1 | Closing flag of last packet sent |
| rx_level | input | 5 | Receive FIFO fill level |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| rx_flag | input | 1 | Receiver detected a flag |
| rx_eop | input | 1 | Receiver found end of packet |
| rx_abort | input | 1 | Receiver detected abort sequence |
| rx_enable | output | 1 | Receiver allowed to run |
| tx_abort | output | 1 | Command to send an abort sequence |
| tx_prio_hi | output | 1 | Transmit priority indication |

## Verification
The assertions check on every cycle that:
- latched bits survive all cycles without a read;
- a read with no new events leaves the status empty and `irq` low;
- a collision event appears only in terminal mode with the transmitter on;
- the transmit-low event coincides with a pure pop;
- overflow, underrun and closing-flag completion produce their receiver, abort and priority effects one cycle later.

Only the bench scenarios can show the exact bit positions seen by the CPU and the mask gating of each source. They also cover the threshold crossings that must not fire, such as filling the transmit FIFO to four or combining a push with a pop. Finally, they show that a collision latched before a switch to network mode becomes invisible.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;

  localparam int NSRC = 8;

  // status / mask bit positions (shared by both registers)
  localparam int BIT_COLL   = 7;
  localparam int BIT_RXEOP  = 6;
  localparam int BIT_TXEOP  = 5;
  localparam int BIT_FABORT = 4;
  localparam int BIT_TXLOW  = 3;
  localparam int BIT_TXUND  = 2;
  localparam int BIT_RXFULL = 1;
  localparam int BIT_RXOVF  = 0;

  // level reaches 'mark' by draining one byte
  function automatic logic drain_to(int unsigned lvl, logic pop, logic push,
                                    int unsigned mark);
    return pop && !push && (lvl == mark + 1);
  endfunction

  // level reaches 'mark' by filling one byte
  function automatic logic fill_to(int unsigned lvl, logic push, logic pop,
                                   int unsigned mark);
    return push && !pop && (lvl + 1 == mark);
  endfunction

  // write attempt into a full buffer
  function automatic logic write_when_full(int unsigned lvl, logic push,
                                           logic pop, int unsigned depth);
    return push && !pop && (lvl >= depth);
  endfunction

  // echo/D-bit mismatch in the mode where it counts
  function automatic logic echo_mismatch(logic te, logic en, logic stb,
                                         logic dbit, logic echo);
    return te && en && stb && (dbit != echo);
  endfunction

endpackage

// File: rtl/hdlc_irq_events.sv
module hdlc_irq_events
  import hdlc_irq_pkg::*;
#(
  parameter int TX_DEPTH     = 16,
  parameter int RX_DEPTH     = 16,
  parameter int TX_LOW_MARK  = 4,
  parameter int RX_FULL_MARK = 15,
  localparam int TLW = $clog2(TX_DEPTH + 1),
  localparam int RLW = $clog2(RX_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            te_mode,
  input  logic            tx_en,
  input  logic            dbit_strobe,
  input  logic            tx_dbit,
  input  logic            echo_bit,
  input  logic [TLW-1:0]  tx_level,
  input  logic            tx_push,
  input  logic            tx_pop,
  input  logic            tx_pop_eop,
  input  logic            tx_close_done,
  input  logic [RLW-1:0]  rx_level,
  input  logic            rx_push,
  input  logic            rx_pop,
  input  logic            rx_eop,
  input  logic            rx_abort,
  output logic [NSRC-1:0] evt
);

  logic coll_evt, txlow_evt, txund_evt, rxfull_evt, rxovf_evt;

  assign coll_evt   = echo_mismatch(te_mode, tx_en, dbit_strobe, tx_dbit, echo_bit);
  assign txlow_evt  = drain_to(int'(tx_level), tx_pop, tx_push, TX_LOW_MARK);
  assign txund_evt  = drain_to(int'(tx_level), tx_pop, tx_push, 0) && !tx_pop_eop;
  assign rxfull_evt = fill_to(int'(rx_level), rx_push, rx_pop, RX_FULL_MARK);
  assign rxovf_evt  = write_when_full(int'(rx_level), rx_push, rx_pop, RX_DEPTH);

  always_comb begin
    evt             = '0;
    evt[BIT_COLL]   = coll_evt;
    evt[BIT_RXEOP]  = rx_eop || rx_abort;
    evt[BIT_TXEOP]  = tx_close_done;
    evt[BIT_FABORT] = rx_abort;
    evt[BIT_TXLOW]  = txlow_evt;
    evt[BIT_TXUND]  = txund_evt;
    evt[BIT_RXFULL] = rxfull_evt;
    evt[BIT_RXOVF]  = rxovf_evt;
  end

  // R4
  coll_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |-> (te_mode && tx_en));

  // R8
  txlow_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txlow_evt |-> (tx_pop && !tx_push));

endmodule

// File: rtl/hdlc_irq_status.sv
module hdlc_irq_status
  import hdlc_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_strobe,
  input  logic            te_mode,
  input  logic [NSRC-1:0] evt,
  output logic [NSRC-1:0] status_view
);

  logic [NSRC-1:0] st_q;
  logic [NSRC-1:0] gate;

  // new events win over the clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= (rd_strobe ? '0 : st_q) | evt;
  end

  always_comb begin
    gate           = '1;
    gate[BIT_COLL] = te_mode;
  end

  assign status_view = st_q & gate;

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> ((st_q & $past(st_q)) == $past(st_q)));

  // R2
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && evt == '0) |=> (st_q == '0));

  // R2
  evt_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> ((st_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/hdlc_irq_effects.sv
module hdlc_irq_effects
  import hdlc_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            rx_flag,
  input  logic            tx_pop,
  output logic            rx_enable,
  output logic            tx_abort,
  output logic            tx_prio_hi
);

  logic rx_halt_q, abort_q, prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_halt_q <= 1'b0;
      abort_q   <= 1'b0;
      prio_q    <= 1'b0;
    end else begin
      if (evt[BIT_RXOVF])  rx_halt_q <= 1'b1;
      else if (rx_flag)    rx_halt_q <= 1'b0;
      abort_q <= evt[BIT_TXUND];
      if (evt[BIT_TXEOP])  prio_q <= 1'b0;
      else if (tx_pop)     prio_q <= 1'b1;
    end
  end

  assign rx_enable  = !rx_halt_q;
  assign tx_abort   = abort_q;
  assign tx_prio_hi = prio_q;

  // R11
  ovf_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[BIT_RXOVF] |=> !rx_enable);

  // R11
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && !rx_flag) |=> !rx_enable);

  // R9
  und_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[BIT_TXUND] |=> tx_abort);

  // R7
  prio_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[BIT_TXEOP] |=> !tx_prio_hi);

endmodule

// File: rtl/hdlc_irq_unit.sv
module hdlc_irq_unit
  import hdlc_irq_pkg::*;
#(
  parameter int TX_DEPTH     = 16,
  parameter int RX_DEPTH     = 16,
  parameter int TX_LOW_MARK  = 4,
  parameter int RX_FULL_MARK = 15,
  localparam int TLW = $clog2(TX_DEPTH + 1),
  localparam int RLW = $clog2(RX_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_cs,
  input  logic            cpu_we,
  input  logic [NSRC-1:0] cpu_wdata,
  output logic [NSRC-1:0] cpu_rdata,
  output logic            irq,
  input  logic            te_mode,
  input  logic            tx_en,
  input  logic            dbit_strobe,
  input  logic            tx_dbit,
  input  logic            echo_bit,
  input  logic [TLW-1:0]  tx_level,
  input  logic            tx_push,
  input  logic            tx_pop,
  input  logic            tx_pop_eop,
  input  logic            tx_close_done,
  input  logic [RLW-1:0]  rx_level,
  input  logic            rx_push,
  input  logic            rx_pop,
  input  logic            rx_flag,
  input  logic            rx_eop,
  input  logic            rx_abort,
  output logic            rx_enable,
  output logic            tx_abort,
  output logic            tx_prio_hi
);

  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] status_view;
  logic [NSRC-1:0] mask_q;
  logic            rd_strobe, wr_strobe;

  assign rd_strobe = cpu_cs && !cpu_we;
  assign wr_strobe = cpu_cs &&  cpu_we;

  hdlc_irq_events #(
    .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH),
    .TX_LOW_MARK(TX_LOW_MARK), .RX_FULL_MARK(RX_FULL_MARK)
  ) u_events (
    .clk(clk), .rst_n(rst_n),
    .te_mode(te_mode), .tx_en(tx_en), .dbit_strobe(dbit_strobe),
    .tx_dbit(tx_dbit), .echo_bit(echo_bit),
    .tx_level(tx_level), .tx_push(tx_push), .tx_pop(tx_pop),
    .tx_pop_eop(tx_pop_eop), .tx_close_done(tx_close_done),
    .rx_level(rx_level), .rx_push(rx_push), .rx_pop(rx_pop),
    .rx_eop(rx_eop), .rx_abort(rx_abort),
    .evt(evt)
  );

  hdlc_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .te_mode(te_mode),
    .evt(evt), .status_view(status_view)
  );

  hdlc_irq_effects u_effects (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rx_flag(rx_flag), .tx_pop(tx_pop),
    .rx_enable(rx_enable), .tx_abort(tx_abort), .tx_prio_hi(tx_prio_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (wr_strobe) mask_q <= cpu_wdata;
  end

  assign cpu_rdata = status_view;
  assign irq       = |(status_view & mask_q);

  // R3
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && evt == '0) |=> !irq);

  // R4
  nt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !te_mode |-> !cpu_rdata[BIT_COLL]);

endmodule

// File: tb/sim_hdlc_irq_unit.sv
`timescale 1ns/1ps
module sim_hdlc_irq_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_cs = 0, cpu_we = 0;
  logic [7:0] cpu_wdata = 0;
  logic [7:0] cpu_rdata;
  logic       irq;
  logic       te_mode = 0, tx_en = 0, dbit_strobe = 0, tx_dbit = 0, echo_bit = 0;
  logic [4:0] tx_level = 0, rx_level = 0;
  logic       tx_push = 0, tx_pop = 0, tx_pop_eop = 0, tx_close_done = 0;
  logic       rx_push = 0, rx_pop = 0, rx_flag = 0, rx_eop = 0, rx_abort = 0;
  logic       rx_enable, tx_abort, tx_prio_hi;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  hdlc_irq_unit u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    cpu_cs = 0; cpu_we = 0; dbit_strobe = 0;
    tx_push = 0; tx_pop = 0; tx_pop_eop = 0; tx_close_done = 0;
    rx_push = 0; rx_pop = 0; rx_flag = 0; rx_eop = 0; rx_abort = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic write_mask(input logic [7:0] m);
    cpu_cs = 1; cpu_we = 1; cpu_wdata = m;
    tick();
  endtask

  task automatic read_status(output logic [7:0] v);
    cpu_cs = 1; cpu_we = 0;
    #1 v = cpu_rdata;
    tick();
  endtask

  task automatic t_reset();
    chk("R1 status", cpu_rdata, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 rx_enable", rx_enable, 1);
    chk("R1 tx_abort", tx_abort, 0);
    chk("R1 prio", tx_prio_hi, 0);
  endtask

  task automatic t_mask_read();
    logic [7:0] v;
    write_mask(8'h00);
    rx_eop = 1; tick();
    chk("R3 masked off irq", irq, 0);
    write_mask(8'h40);
    chk("R1 R3 mask enables irq", irq, 1);
    write_mask(8'h00);
    chk("R3 mask removed", irq, 0);
    read_status(v);
    chk("R2 read value", v, 8'h40);
    chk("R2 cleared", cpu_rdata, 8'h00);
  endtask

  task automatic t_read_collide();
    logic [7:0] v;
    rx_eop = 1; tick();
    cpu_cs = 1; cpu_we = 0; rx_abort = 1;
    #1 v = cpu_rdata;
    tick();
    chk("R2 read sees older bit", v, 8'h40);
    chk("R2 same-cycle event kept", cpu_rdata, 8'h50);
    read_status(v);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    write_mask(8'h80);
    te_mode = 1; tx_en = 1; tx_dbit = 1; echo_bit = 1; dbit_strobe = 1; tick();
    chk("R4 match no event", cpu_rdata, 8'h00);
    tx_dbit = 1; echo_bit = 0; dbit_strobe = 1; tick();
    chk("R4 mismatch sets", cpu_rdata, 8'h80);
    chk("R4 irq", irq, 1);
    te_mode = 0; #1;
    chk("R4 hidden in NT", cpu_rdata, 8'h00);
    chk("R4 no irq in NT", irq, 0);
    read_status(v);
    dbit_strobe = 1; tick();
    te_mode = 1; #1;
    chk("R4 NT mismatch ignored", cpu_rdata, 8'h00);
    tx_en = 0; dbit_strobe = 1; tick();
    chk("R4 tx disabled ignored", cpu_rdata, 8'h00);
    te_mode = 0; write_mask(8'h00);
  endtask

  task automatic t_rx_events();
    logic [7:0] v;
    rx_abort = 1; tick();
    read_status(v);
    chk("R5 R6 abort bits", v, 8'h50);
    rx_eop = 1; tick();
    read_status(v);
    chk("R5 eop only", v, 8'h40);
  endtask

  task automatic t_tx_eop();
    logic [7:0] v;
    tx_level = 10; tx_pop = 1; tick();
    chk("R7 prio high", tx_prio_hi, 1);
    tx_close_done = 1; tick();
    chk("R7 prio low", tx_prio_hi, 0);
    read_status(v);
    chk("R7 status", v, 8'h20);
  endtask

  task automatic t_tx_low();
    logic [7:0] v;
    tx_level = 5; tx_pop = 1; tick();
    read_status(v);
    chk("R8 drain to 4", v, 8'h08);
    tx_level = 3; tx_push = 1; tick();
    chk("R8 fill to 4 ignored", cpu_rdata, 8'h00);
    tx_level = 5; tx_pop = 1; tx_push = 1; tick();
    chk("R8 pop+push ignored", cpu_rdata, 8'h00);
    tx_close_done = 1; tick(); read_status(v);
  endtask

  task automatic t_underrun();
    logic [7:0] v;
    tx_level = 1; tx_pop = 1; tx_pop_eop = 0; tick();
    chk("R9 status", cpu_rdata, 8'h02 << 1);
    chk("R9 abort pulse", tx_abort, 1);
    tick();
    chk("R9 abort one cycle", tx_abort, 0);
    read_status(v);
    tx_level = 1; tx_pop = 1; tx_pop_eop = 1; tick();
    chk("R9 eop empty ignored", cpu_rdata, 8'h00);
    chk("R9 no abort", tx_abort, 0);
    tx_close_done = 1; tick(); read_status(v);
  endtask

  task automatic t_rx_full();
    logic [7:0] v;
    rx_level = 13; rx_push = 1; tick();
    chk("R10 below mark", cpu_rdata, 8'h00);
    rx_level = 14; rx_push = 1; tick();
    read_status(v);
    chk("R10 reach 15", v, 8'h02);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    rx_level = 16; rx_push = 1; rx_pop = 1; tick();
    chk("R11 push+pop no overflow", cpu_rdata, 8'h00);
    rx_level = 16; rx_push = 1; tick();
    chk("R11 status", cpu_rdata, 8'h01);
    chk("R11 rx disabled", rx_enable, 0);
    tick(); tick();
    chk("R11 stays disabled", rx_enable, 0);
    rx_flag = 1; tick();
    chk("R11 flag re-enables", rx_enable, 1);
    read_status(v);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mask_read();
    t_read_collide();
    t_collision();
    t_rx_events();
    t_tx_eop();
    t_tx_low();
    t_underrun();
    t_rx_full();
    t_overflow();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule